// File: doc/BRIEF.md
# Configurable 8-bit GPIO port with pin-edge interrupt

The block is an eight-pin general-purpose I/O port reached through a small register bus. Each pin is set on its own to one of four modes: plain input, input with pull-up, push-pull output or open-drain output. A data register holds the output latch on write. On read, the data register returns the synchronized pin levels. A separate per-pin register turns on pull-ups. The pad side is modelled as four vectors: output enable, output value, pull-up enable and the raw pin input.

Pin 7 also serves as an external interrupt source. A configuration register holds an enable bit and a two-bit edge selector. When the selected edge is seen on the synchronized pin 7 while the interrupt is enabled, a sticky pending flag is set. The active-low IRQ line is asserted for as long as the flag is set and the interrupt is enabled. Software clears the flag by writing a zero to it.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset all mode fields, the output latch, the pull-up register, the interrupt configuration and the pending flag are 0. As a result `oe_o`=0, `pu_o`=0 and `irq_no`=1.
- R2: Mode fields are 2 bits per pin, encoded 00 input, 01 input with pull-up, 10 push-pull, 11 open-drain. Address 1 holds pins 0–1 in bits [3:0] and address 2 holds pins 2–5 in bits [7:0]. Address 3 holds pins 6–7 in bits [3:0]. Pin n uses bits [2k+1:2k], where k is n minus the group's first pin. Bits [7:4] of addresses 1 and 3 read 0, and unmapped addresses (7) read 0.
- R3: A push-pull pin drives `oe_o`=1 and `out_o` equal to its latch bit.
- R4: An open-drain pin drives `out_o`=0 and sets `oe_o` only while its latch bit is 0.
- R5: `pu_o[n]` is 1 when pin n is in mode 01, or when bit n of the pull-up register (address 4) is set and the pin is not in push-pull mode.
- R6: A write to address 0 loads the output latch. A read of address 0 returns `pin_i` delayed through a two-flop synchronizer: a change before clock edge k is visible after edge k+1.
- R7: Address 5 holds the interrupt enable in bit 0 and the edge select in bits [3:2]: 00 off, 01 falling, 10 rising, 11 both. The pending flag (address 6, bit 0) sets after the third clock edge following a matching change on `pin_i[7]`.
- R8: With the enable bit at 0 or the edge select at 00, no change on pin 7 sets the pending flag.
- R9: Writing 0 to address 6 bit 0 clears the pending flag, and writing 1 leaves it unchanged. A new edge in the same cycle as a clearing write wins and keeps the flag set.
- R10: `irq_no` is 0 exactly when the pending flag and the enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_i | input | 8 | Raw pad input levels |
| oe_o | output | 8 | Pad output enables |
| out_o | output | 8 | Pad output values |
| pu_o | output | 8 | Pad pull-up enables |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
The bench checks four pin-mode risks:
- The pin groups in the three mode registers: a design with a misplaced group would drive the wrong pad.
- The unused upper bits of the two short registers: if these were stored, they would read back as ones.
- Open-drain pins: a design that drives a high level would show `out_o`=1 with `oe_o` set.
- Pull-ups on push-pull pins: a design that leaves them on would hold `pu_o` high.

On the interrupt side, the bench covers each edge-select code, the disabled states and a clearing write that lands on the same cycle as a fresh edge; a design that let the clear win would drop that interrupt. It also checks the exact synchronizer latency, where a missing or extra flop moves the data read and the pending set by one cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PINS = 8;
  localparam int unsigned DW   = 8;
  localparam int unsigned AW   = 3;
  localparam int unsigned MW   = 2 * PINS;

  typedef enum logic [1:0] {
    PM_IN    = 2'b00,
    PM_IN_PU = 2'b01,
    PM_PUSH  = 2'b10,
    PM_OD    = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [AW-1:0] A_DATA     = 3'd0;
  localparam logic [AW-1:0] A_MODE_LO  = 3'd1;
  localparam logic [AW-1:0] A_MODE_MID = 3'd2;
  localparam logic [AW-1:0] A_MODE_HI  = 3'd3;
  localparam logic [AW-1:0] A_PULL     = 3'd4;
  localparam logic [AW-1:0] A_IRQ_CFG  = 3'd5;
  localparam logic [AW-1:0] A_IRQ_PEND = 3'd6;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PINS-1:0] pins_sync_i,
  input  logic          pend_i,
  output logic [DW-1:0] rdata_o,
  output logic [PINS-1:0] latch_o,
  output logic [MW-1:0] modes_o,
  output logic [PINS-1:0] pull_o,
  output logic          irq_en_o,
  output edge_sel_e     edge_sel_o,
  output logic          pend_clr_o
);
  logic [3:0] mode_lo_q, mode_hi_q;
  logic [7:0] mode_mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o    <= '0;
      mode_lo_q  <= '0;
      mode_mid_q <= '0;
      mode_hi_q  <= '0;
      pull_o     <= '0;
      irq_en_o   <= 1'b0;
      edge_sel_o <= EDGE_OFF;
    end else if (wr_i) begin
      unique case (addr_i)
        A_DATA:     latch_o    <= wdata_i[PINS-1:0];
        A_MODE_LO:  mode_lo_q  <= wdata_i[3:0];
        A_MODE_MID: mode_mid_q <= wdata_i;
        A_MODE_HI:  mode_hi_q  <= wdata_i[3:0];
        A_PULL:     pull_o     <= wdata_i[PINS-1:0];
        A_IRQ_CFG: begin
          irq_en_o   <= wdata_i[0];
          edge_sel_o <= edge_sel_e'(wdata_i[3:2]);
        end
        default: ;
      endcase
    end
  end

  // Only a zero written to the pending bit clears it
  assign pend_clr_o = wr_i && (addr_i == A_IRQ_PEND) && !wdata_i[0];
  assign modes_o    = {mode_hi_q, mode_mid_q, mode_lo_q};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DATA:     rdata_o = pins_sync_i;
      A_MODE_LO:  rdata_o = {4'b0, mode_lo_q};
      A_MODE_MID: rdata_o = mode_mid_q;
      A_MODE_HI:  rdata_o = {4'b0, mode_hi_q};
      A_PULL:     rdata_o = pull_o;
      A_IRQ_CFG:  rdata_o = {4'b0, edge_sel_o, 1'b0, irq_en_o};
      A_IRQ_PEND: rdata_o = {7'b0, pend_i};
      default:    rdata_o = '0;
    endcase
  end

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_MODE_MID) |=> $stable(mode_mid_q));
  p_lo_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_MODE_LO) |=> $stable(mode_lo_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
(
  input  logic [MW-1:0]   modes_i,
  input  logic [PINS-1:0] latch_i,
  input  logic [PINS-1:0] pull_i,
  output logic [PINS-1:0] oe_o,
  output logic [PINS-1:0] out_o,
  output logic [PINS-1:0] pu_o
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'(modes_i[2*i +: 2]);
    always_comb begin
      oe_o[i]  = 1'b0;
      out_o[i] = 1'b0;
      pu_o[i]  = pull_i[i];
      unique case (mode)
        PM_IN:    ;
        PM_IN_PU: pu_o[i] = 1'b1;
        PM_PUSH: begin
          oe_o[i]  = 1'b1;
          out_o[i] = latch_i[i];
          pu_o[i]  = 1'b0;
        end
        PM_OD:    oe_o[i] = !latch_i[i];  // pull low only, release on 1
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  logic      irq_en_i,
  input  edge_sel_e edge_sel_i,
  input  logic      clr_i,
  output logic      pend_o,
  output logic      irq_no
);
  logic prev_q, hit;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_FALL: hit = prev_q & ~pin_i;
      EDGE_RISE: hit = ~prev_q & pin_i;
      EDGE_BOTH: hit = prev_q ^ pin_i;
      default:   hit = 1'b0;
    endcase
    hit = hit & irq_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (hit) pend_o <= 1'b1;       // set beats clear
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  assign irq_no = ~(pend_o & irq_en_i);

  p_no_set_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i || edge_sel_i == EDGE_OFF) |=> !$rose(pend_o));
  p_one_no_effect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
  p_irq_needs_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (pend_o && irq_en_i));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IRQ_PIN     = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] oe_o,
  output logic [PINS-1:0] out_o,
  output logic [PINS-1:0] pu_o,
  output logic          irq_no
);
  logic [PINS-1:0] pins_sync, latch, pull;
  logic [MW-1:0]   modes;
  logic            irq_en, pend, pend_clr;
  edge_sel_e       edge_sel;

  gpio_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pins_sync)
  );

  gpio_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .pins_sync_i(pins_sync), .pend_i(pend), .rdata_o,
    .latch_o(latch), .modes_o(modes), .pull_o(pull),
    .irq_en_o(irq_en), .edge_sel_o(edge_sel), .pend_clr_o(pend_clr)
  );

  gpio_pad_ctrl u_pad (
    .modes_i(modes), .latch_i(latch), .pull_i(pull),
    .oe_o, .out_o, .pu_o
  );

  gpio_edge_irq u_irq (
    .clk_i, .rst_ni, .pin_i(pins_sync[IRQ_PIN]), .irq_en_i(irq_en),
    .edge_sel_i(edge_sel), .clr_i(pend_clr), .pend_o(pend), .irq_no
  );

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    p_od_no_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (oe_o[i] && out_o[i]) |-> (modes[2*i +: 2] == PM_PUSH));
    p_push_no_pull_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (modes[2*i +: 2] == PM_PUSH) |-> !pu_o[i]);
  end
endmodule

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;
  logic       clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, irq_no;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o, pin_i = '0, oe_o, out_o, pu_o;

  int checks = 0, failures = 0;
  string cur_tag = "R1";

  // reference state
  logic [3:0] m_lo, m_hi;
  logic [7:0] m_mid, m_lat, m_pur;
  logic       m_en, m_pend;
  logic [1:0] m_esel;
  logic [7:0] pin_q[$];

  always #2 clk_i = ~clk_i;

  gpio_edge_port dut (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(int n);
    if (n < 2) return m_lo[2*n +: 2];
    else if (n < 6) return m_mid[2*(n-2) +: 2];
    else return m_hi[2*(n-6) +: 2];
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return pin_q[1];
      3'd1: return {4'h0, m_lo};
      3'd2: return m_mid;
      3'd3: return {4'h0, m_hi};
      3'd4: return m_pur;
      3'd5: return {4'h0, m_esel, 1'b0, m_en};
      3'd6: return {7'h0, m_pend};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_lo = 0; m_hi = 0; m_mid = 0; m_lat = 0; m_pur = 0;
    m_en = 0; m_pend = 0; m_esel = 0;
    pin_q = '{8'h00, 8'h00, 8'h00};
  endtask

  task automatic compare();
    logic [7:0] e_oe, e_out, e_pu;
    for (int n = 0; n < 8; n++) begin
      logic [1:0] md = mode_of(n);
      e_oe[n]  = (md == 2'b10) || (md == 2'b11 && !m_lat[n]);
      e_out[n] = (md == 2'b10) && m_lat[n];
      e_pu[n]  = (md == 2'b01) || (m_pur[n] && md != 2'b10);
    end
    check(oe_o === e_oe, cur_tag, "oe_o", oe_o, e_oe);
    check(out_o === e_out, cur_tag, "out_o", out_o, e_out);
    check(pu_o === e_pu, cur_tag, "pu_o", pu_o, e_pu);
    check(irq_no === !(m_pend && m_en), cur_tag, "irq_no",
          {7'h0, irq_no}, {7'h0, !(m_pend && m_en)});
    check(rdata_o === exp_rd(addr_i), cur_tag, "rdata_o", rdata_o, exp_rd(addr_i));
  endtask

  // one clock: drive, edge, update reference, compare at negedge
  task automatic cyc(input bit w, input logic [2:0] a, input logic [7:0] d);
    logic hit, s2, pv;
    wr_i = w; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    s2 = pin_q[1][7]; pv = pin_q[2][7];
    case (m_esel)
      2'b01: hit = pv && !s2;
      2'b10: hit = !pv && s2;
      2'b11: hit = pv != s2;
      default: hit = 1'b0;
    endcase
    hit = hit && m_en;
    if (hit) m_pend = 1'b1;
    else if (w && a == 3'd6 && !d[0]) m_pend = 1'b0;
    if (w) case (a)
      3'd0: m_lat = d;
      3'd1: m_lo = d[3:0];
      3'd2: m_mid = d;
      3'd3: m_hi = d[3:0];
      3'd4: m_pur = d;
      3'd5: begin m_en = d[0]; m_esel = d[3:2]; end
      default: ;
    endcase
    pin_q.push_front(pin_i);
    void'(pin_q.pop_back());
    @(negedge clk_i);
    wr_i = 1'b0;
    compare();
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(1'b0, a, 8'h00);
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int k = 0; k < n; k++) rd(a);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset values seen at the ports
    check(oe_o === 8'h00, "R1", "oe_o", oe_o, 8'h00);
    check(pu_o === 8'h00, "R1", "pu_o", pu_o, 8'h00);
    check(irq_no === 1'b1, "R1", "irq_no", {7'h0, irq_no}, 8'h01);
    for (int a = 1; a < 8; a++) begin
      addr_i = 3'(a); #0.1;
      check(rdata_o === 8'h00, "R1", "reset readback", rdata_o, 8'h00);
    end
    rst_ni = 1'b1;
    rd(3'd0);

    cur_tag = "R2";
    cyc(1, 3'd1, 8'hFF); rd(3'd1);
    check(rdata_o === 8'h0F, "R2", "lo upper bits", rdata_o, 8'h0F);
    cyc(1, 3'd3, 8'h3C); rd(3'd3);
    check(rdata_o === 8'h0C, "R2", "hi upper bits", rdata_o, 8'h0C);
    cyc(1, 3'd2, 8'hA5); rd(3'd2); rd(3'd7);

    cur_tag = "R3";
    cyc(1, 3'd1, 8'h0A); cyc(1, 3'd2, 8'hAA); cyc(1, 3'd3, 8'h0A);
    cyc(1, 3'd0, 8'h5A);
    check(oe_o === 8'hFF && out_o === 8'h5A, "R3", "push-pull out", out_o, 8'h5A);
    cyc(1, 3'd0, 8'hC3);

    cur_tag = "R4";
    cyc(1, 3'd1, 8'h0F); cyc(1, 3'd2, 8'hFF); cyc(1, 3'd3, 8'h0F);
    cyc(1, 3'd0, 8'h0F);
    check(oe_o === 8'hF0 && out_o === 8'h00, "R4", "open-drain oe", oe_o, 8'hF0);
    cyc(1, 3'd0, 8'hAA);

    cur_tag = "R5";
    cyc(1, 3'd1, 8'h04); cyc(1, 3'd2, 8'h1B); cyc(1, 3'd3, 8'h09);
    cyc(1, 3'd4, 8'hFF);
    cyc(1, 3'd4, 8'h81); cyc(1, 3'd4, 8'h00); rd(3'd4);

    cur_tag = "R6";
    cyc(1, 3'd1, 8'h00); cyc(1, 3'd2, 8'h00); cyc(1, 3'd3, 8'h00);
    pin_i = 8'h3C; rd(3'd0);
    check(rdata_o === 8'h00, "R6", "sync one edge", rdata_o, 8'h00);
    rd(3'd0);
    check(rdata_o === 8'h3C, "R6", "sync two edges", rdata_o, 8'h3C);
    pin_i = 8'hA5; idle(3, 3'd0);
    pin_i = 8'h00; idle(3, 3'd0);

    cur_tag = "R7";
    for (int s = 1; s < 4; s++) begin
      cyc(1, 3'd5, 8'((s << 2) | 1));
      pin_i[7] = 1'b1; idle(4, 3'd6);
      cyc(1, 3'd6, 8'h00);
      pin_i[7] = 1'b0; idle(4, 3'd6);
      cyc(1, 3'd6, 8'h00);
    end
    cyc(1, 3'd5, 8'h09); pin_i[7] = 1'b1; rd(3'd6); rd(3'd6);
    check(rdata_o === 8'h00, "R7", "pending before third edge", rdata_o, 8'h00);
    rd(3'd6);
    check(rdata_o === 8'h01, "R7", "pending at third edge", rdata_o, 8'h01);

    cur_tag = "R9";
    cyc(1, 3'd6, 8'h01); rd(3'd6);
    check(rdata_o === 8'h01, "R9", "write one kept", rdata_o, 8'h01);
    cyc(1, 3'd6, 8'h00);
    check(rdata_o === 8'h00, "R9", "write zero clears", rdata_o, 8'h00);
    cyc(1, 3'd5, 8'h0D);
    pin_i[7] = 1'b0; rd(3'd6); rd(3'd6);
    cyc(1, 3'd6, 8'h00);  // lands with the falling hit
    check(rdata_o === 8'h01, "R9", "set beats clear", rdata_o, 8'h01);

    cur_tag = "R10";
    cyc(1, 3'd5, 8'h0C);
    check(irq_no === 1'b1, "R10", "irq off when disabled", {7'h0, irq_no}, 8'h01);
    cyc(1, 3'd5, 8'h0D);
    check(irq_no === 1'b0, "R10", "irq on when enabled", {7'h0, irq_no}, 8'h00);
    cyc(1, 3'd6, 8'h00); rd(3'd6);

    cur_tag = "R8";
    cyc(1, 3'd5, 8'h01);
    for (int k = 0; k < 3; k++) begin pin_i[7] = ~pin_i[7]; idle(4, 3'd6); end
    check(rdata_o === 8'h00, "R8", "select off", rdata_o, 8'h00);
    cyc(1, 3'd5, 8'h0C);
    for (int k = 0; k < 3; k++) begin pin_i[7] = ~pin_i[7]; idle(4, 3'd6); end
    check(rdata_o === 8'h00, "R8", "enable off", rdata_o, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule